// File: doc/BRIEF.md
# Qualified Duty-Cycle Rate Meter

This block watches one status bit and one qualify input for a fixed window of `2^WIN_LOG2` clock cycles. For each window it reports two ratios as unsigned fixed-point numbers in which `2^FRAC_W` stands for 100 percent. With the default `FRAC_W` of 15 the results are 16 bits wide and `0x8000` means full scale.

The qualify ratio is the share of all cycles in the window during which the qualify input was high. The monitored ratio is the share of qualified cycles during which the monitored bit was also high. Cycles without qualify do not count toward the monitored ratio at all. A status path with several flags uses one instance per flag, and each flag gets its own result.

Windows run back to back from the first clock after reset. A sampled window is divided while the next window is already accumulating. The result is published once, with a single-cycle strobe, and then held. A parameter selects the divider:
- A serial divider gives one quotient bit per cycle.
- An unrolled divider finishes in a single cycle.

Top module: `qual_rate_meter`

## Requirements
- R1: Windows are exactly `2^WIN_LOG2` consecutive cycles and follow each other with no gap. The first window's first sample is taken at the first rising clock edge after reset is released.
- R2: The qualify result equals floor(Q * 2^FRAC_W / 2^WIN_LOG2), where Q is the number of cycles in the window with `qual_i` high. A window that is qualified on every cycle yields exactly 2^FRAC_W (0x8000 by default).
- R3: The monitored result equals floor(H * 2^FRAC_W / Q), where H is the number of cycles with both `mon_bit_i` and `qual_i` high. A high `mon_bit_i` on a cycle with `qual_i` low has no effect on either result.
- R4: A window with no qualified cycle yields 0 for both results.
- R5: Neither result ever exceeds 2^FRAC_W. A window whose qualified cycles all have the monitored bit high yields exactly 2^FRAC_W for the monitored result, even when there is only one qualified cycle.
- R6: `ratio_vld_o` is high for exactly one cycle per window, and successive strobes are `2^WIN_LOG2` cycles apart.
- R7: The results and the strobe appear a fixed number of rising edges after the edge that samples a window's last cycle: FRAC_W+2 edges with the serial divider and 2 edges with the unrolled divider.
- R8: Both results change only in the cycle in which `ratio_vld_o` is high, and hold their value at all other times.
- R9: Asserting `rst_n` low clears both results, the strobe and all partial window counts at once. After release a fresh window begins, and counts from before the reset have no effect on it.
- R10: The serial and unrolled divider variants publish identical values for identical input streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_bit_i | input | 1 | Monitored status bit |
| qual_i | input | 1 | Test-qualify input; gates counting of `mon_bit_i` |
| mon_ratio_o | output | FRAC_W+1 | Monitored-bit share of qualified cycles, 2^FRAC_W = 100 % |
| qual_ratio_o | output | FRAC_W+1 | Qualified share of all window cycles, 2^FRAC_W = 100 % |
| ratio_vld_o | output | 1 | One-cycle pulse marking freshly published results |

## Verification
The bench goes after the corner cases of the ratio arithmetic, each in a window of its own:
- **Fully qualified window.** A full window must give exactly 0x8000 for both results. An off-by-one in the window counter or the divider would show up as 0x7FFF, or as a wrapped value 0x0000.
- **No qualified cycle.** This divides by zero. A design without the guard would publish whatever the divider leaves behind when the denominator is zero.
- **Monitored bit high only while unqualified.** A design that counted every high monitored cycle would report a nonzero monitored ratio.
- **Single qualified cycle.** This tests exact full scale from the smallest possible denominator.

Random windows of varying density check floor rounding. Both divider variants run against the same expected values, with the strobe expected at a known edge. A wrong latency, a missed window boundary, a late reset or a result that drifts between strobes is reported at the first cycle where it happens.

// File: rtl/rate_meter_pkg.sv
package rate_meter_pkg;

   // Divider implementation choice for the monitored ratio.
   typedef enum logic {
      DIV_SERIAL   = 1'b0,   // one quotient bit per cycle, small area
      DIV_UNROLLED = 1'b1    // whole quotient in one cycle, deep logic
   } rm_div_mode_e;

endpackage

// File: rtl/rm_window_timer.sv
module rm_window_timer #(
   parameter int WIN_LOG2 = 15
) (
   input  logic clk,
   input  logic rst_n,
   output logic win_last
);

   logic [WIN_LOG2-1:0] tick_q;

   // Free-running position inside the window; wraps on its own.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick_q <= '0;
      else        tick_q <= tick_q + 1'b1;
   end

   assign win_last = &tick_q;

endmodule

// File: rtl/rm_accum.sv
module rm_accum #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          win_last,
   output logic [CW-1:0] total
);

   logic [CW-1:0] cnt_q;

   // The total includes the present sample, so the final cycle of a window counts.
   assign total = cnt_q + CW'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (win_last) cnt_q <= '0;
      else               cnt_q <= total;
   end

endmodule

// File: rtl/rm_ratio_div.sv
module rm_ratio_div
   import rate_meter_pkg::*;
#(
   parameter int           CW       = 16,
   parameter int           RES_W    = 16,
   parameter rm_div_mode_e DIV_MODE = DIV_SERIAL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CW-1:0]    num,    // never larger than den
   input  logic [CW-1:0]    den,
   output logic             done,
   output logic [RES_W-1:0] quot    // one integer bit, RES_W-1 fraction bits
);

   // The remainder stays below den (< 2^(CW-1)), so one extra bit holds the shift.
   localparam int RW = CW + 1;

   generate
      if (DIV_MODE == DIV_SERIAL) begin : g_serial
         localparam int SW = (RES_W > 1) ? $clog2(RES_W) : 1;

         logic [RW-1:0]    rem_q;
         logic [RES_W-1:0] acc_q;
         logic [SW-1:0]    step_q;
         logic             busy_q;
         logic             done_q;
         logic [RW-1:0]    part;
         logic             take;

         always_comb begin
            part = start ? RW'(num) : {rem_q[RW-2:0], 1'b0};
            take = (part >= RW'(den));
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rem_q  <= '0;
               acc_q  <= '0;
               step_q <= '0;
               busy_q <= 1'b0;
               done_q <= 1'b0;
            end else begin
               done_q <= 1'b0;
               if (start) begin
                  rem_q  <= take ? (part - RW'(den)) : part;
                  acc_q  <= RES_W'(take);
                  step_q <= SW'(1);
                  busy_q <= 1'b1;
               end else if (busy_q) begin
                  rem_q  <= take ? (part - RW'(den)) : part;
                  acc_q  <= {acc_q[RES_W-2:0], take};
                  step_q <= step_q + 1'b1;
                  if (step_q == SW'(RES_W-1)) begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                  end
               end
            end
         end

         assign done = done_q;
         assign quot = acc_q;
      end else begin : g_unrolled
         logic [RW-1:0]    rem_v;
         logic [RES_W-1:0] quo_v;
         logic [RES_W-1:0] acc_q;
         logic             done_q;

         always_comb begin
            rem_v = RW'(num);
            quo_v = '0;
            for (int k = 0; k < RES_W; k++) begin
               if (k != 0) rem_v = {rem_v[RW-2:0], 1'b0};
               if (rem_v >= RW'(den)) begin
                  rem_v              = rem_v - RW'(den);
                  quo_v[RES_W-1-k]   = 1'b1;
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q  <= '0;
               done_q <= 1'b0;
            end else begin
               done_q <= start;
               if (start) acc_q <= quo_v;
            end
         end

         assign done = done_q;
         assign quot = acc_q;
      end
   endgenerate

endmodule

// File: rtl/qual_rate_meter.sv
module qual_rate_meter
   import rate_meter_pkg::*;
#(
   parameter int           WIN_LOG2 = 15,
   parameter int           FRAC_W   = 15,
   parameter rm_div_mode_e DIV_MODE = DIV_SERIAL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mon_bit_i,
   input  logic              qual_i,
   output logic [FRAC_W:0]   mon_ratio_o,
   output logic [FRAC_W:0]   qual_ratio_o,
   output logic              ratio_vld_o
);

   localparam int CW    = WIN_LOG2 + 1;   // counts reach 2^WIN_LOG2
   localparam int RES_W = FRAC_W + 1;

   // Elaboration-time parameter checks.
   generate
      if (WIN_LOG2 < 5 || WIN_LOG2 > 30) begin : g_bad_win
         $error("qual_rate_meter: WIN_LOG2 must lie in 5..30");
      end
      if (FRAC_W < 1 || FRAC_W > 30) begin : g_bad_frac
         $error("qual_rate_meter: FRAC_W must lie in 1..30");
      end
      if ((64'd1 << WIN_LOG2) <= 64'(FRAC_W + 3)) begin : g_bad_lat
         $error("qual_rate_meter: window shorter than divider latency");
      end
   endgenerate

   logic          win_last;
   logic [CW-1:0] hq_total;
   logic [CW-1:0] q_total;
   logic [CW-1:0] snap_hq_q;
   logic [CW-1:0] snap_q_q;
   logic          start_q;
   logic          div_done;
   logic [RES_W-1:0] div_quot;
   logic [RES_W-1:0] qual_scaled;
   logic [CW+FRAC_W-1:0] qual_wide;

   rm_window_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_last (win_last)
   );

   rm_accum #(.CW(CW)) u_acc_hq (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (mon_bit_i & qual_i),
      .win_last (win_last),
      .total    (hq_total)
   );

   rm_accum #(.CW(CW)) u_acc_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (qual_i),
      .win_last (win_last),
      .total    (q_total)
   );

   // Freeze the finished window; it stays put while the next one accumulates.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_hq_q <= '0;
         snap_q_q  <= '0;
         start_q   <= 1'b0;
      end else begin
         start_q <= win_last;
         if (win_last) begin
            snap_hq_q <= hq_total;
            snap_q_q  <= q_total;
         end
      end
   end

   rm_ratio_div #(.CW(CW), .RES_W(RES_W), .DIV_MODE(DIV_MODE)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_q),
      .num   (snap_hq_q),
      .den   (snap_q_q),
      .done  (div_done),
      .quot  (div_quot)
   );

   // Scale by 2^FRAC_W / 2^WIN_LOG2: pure wiring.
   assign qual_wide   = {snap_q_q, {FRAC_W{1'b0}}};
   assign qual_scaled = RES_W'(qual_wide >> WIN_LOG2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mon_ratio_o  <= '0;
         qual_ratio_o <= '0;
         ratio_vld_o  <= 1'b0;
      end else begin
         ratio_vld_o <= div_done;
         if (div_done) begin
            mon_ratio_o  <= (snap_q_q == '0) ? '0 : div_quot;
            qual_ratio_o <= qual_scaled;
         end
      end
   end

endmodule

// File: rtl/qual_rate_meter_chk.sv
module qual_rate_meter_chk #(
   parameter int WIN_LOG2 = 15,
   parameter int FRAC_W   = 15
) (
   input logic            clk,
   input logic            rst_n,
   input logic [FRAC_W:0] mon_ratio_o,
   input logic [FRAC_W:0] qual_ratio_o,
   input logic            ratio_vld_o
);

   localparam logic [FRAC_W:0]   FULL    = {1'b1, {FRAC_W{1'b0}}};
   localparam logic [WIN_LOG2:0] GAP_EXP = {1'b0, {WIN_LOG2{1'b1}}};

   logic [WIN_LOG2:0] gap_q;
   logic              seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (ratio_vld_o) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else begin
         gap_q <= gap_q + 1'b1;
      end
   end

   // R6
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_vld_o |=> !ratio_vld_o);

   // R6
   strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_vld_o && seen_q) |-> (gap_q == GAP_EXP));

   // R8
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ratio_vld_o |-> ($stable(mon_ratio_o) && $stable(qual_ratio_o)));

   // R5
   full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_ratio_o <= FULL) && (qual_ratio_o <= FULL));

   // R3
   qualified_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_vld_o && (mon_ratio_o != '0)) |-> (qual_ratio_o != '0));

endmodule

bind qual_rate_meter qual_rate_meter_chk #(
   .WIN_LOG2 (WIN_LOG2),
   .FRAC_W   (FRAC_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mon_ratio_o  (mon_ratio_o),
   .qual_ratio_o (qual_ratio_o),
   .ratio_vld_o  (ratio_vld_o)
);

// File: tb/qual_rate_meter_test.sv
module qual_rate_meter_test;
   import rate_meter_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int WL         = 6;
   localparam int WIN        = 1 << WL;
   localparam int FRAC       = 15;
   localparam int FULL       = 1 << FRAC;
   localparam int LAT_SER    = FRAC + 2;   // R7 serial
   localparam int LAT_UNR    = 2;          // R7 unrolled

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mon_b = 1'b0;
   logic qual_b = 1'b0;
   logic [15:0] m_s, q_s, m_u, q_u;
   logic v_s, v_u;

   int pe = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;
   int due [2];
   int last_m [2];
   int last_q [2];
   int exp_m = 0;
   int exp_q = 0;
   string exp_tag = "R3";

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) pe <= 0;
      else        pe <= pe + 1;
   end

   qual_rate_meter #(.WIN_LOG2(WL), .FRAC_W(FRAC), .DIV_MODE(DIV_SERIAL)) uut (
      .clk(clk), .rst_n(rst_n), .mon_bit_i(mon_b), .qual_i(qual_b),
      .mon_ratio_o(m_s), .qual_ratio_o(q_s), .ratio_vld_o(v_s));

   qual_rate_meter #(.WIN_LOG2(WL), .FRAC_W(FRAC), .DIV_MODE(DIV_UNROLLED)) uut_unr (
      .clk(clk), .rst_n(rst_n), .mon_bit_i(mon_b), .qual_i(qual_b),
      .mon_ratio_o(m_u), .qual_ratio_o(q_u), .ratio_vld_o(v_u));

   function automatic int ref_qual(input int qc);
      return (qc * FULL) / WIN;
   endfunction

   function automatic int ref_mon(input int hc, input int qc);
      return (qc == 0) ? 0 : (hc * FULL) / qc;
   endfunction

   task automatic check(input string tag, input string what, input int got, input int expv);
      n_chk++;
      if (got != expv) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, expv);
      end
   endtask

   task automatic observe_one(input int i, input logic v, input logic [15:0] m, input logic [15:0] q);
      string nm;
      nm = (i == 0) ? "serial" : "unrolled";
      if (pe == due[i]) begin
         check("R1 R7", {nm, " strobe"}, int'(v), 1);
         check((i == 0) ? exp_tag : {exp_tag, "+R10"}, {nm, " mon"}, int'(m), exp_m);
         check("R2", {nm, " qual"}, int'(q), exp_q);
         last_m[i] = exp_m;
         last_q[i] = exp_q;
         due[i]    = -1;
      end else begin
         check("R6", {nm, " idle strobe"}, int'(v), 0);
         check("R8", {nm, " mon hold"}, int'(m), last_m[i]);
         check("R8", {nm, " qual hold"}, int'(q), last_q[i]);
      end
   endtask

   task automatic observe();
      observe_one(0, v_s, m_s, q_s);
      observe_one(1, v_u, m_u, q_u);
   endtask

   // R9: hold reset for a few cycles and check everything reads zero.
   task automatic reset_phase();
      @(negedge clk);
      rst_n  = 1'b0;
      qual_b = 1'b0;
      mon_b  = 1'b0;
      for (int i = 0; i < 2; i++) begin
         due[i] = -1;
         last_m[i] = 0;
         last_q[i] = 0;
      end
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         check("R9", "serial strobe in reset", int'(v_s), 0);
         check("R9", "serial mon in reset", int'(m_s), 0);
         check("R9", "serial qual in reset", int'(q_s), 0);
         check("R9", "unrolled mon in reset", int'(m_u), 0);
         check("R9", "unrolled qual in reset", int'(q_u), 0);
      end
   endtask

   // Kinds: 0 all on (R5), 1 nothing qualified (R4), 2 qualified but bit low,
   // 3 bit high only unqualified (R3), 4 one qualified high cycle (R5),
   // 5 patterned, 6 fully qualified random bit, other random density.
   task automatic run_window(input int kind, input int ncyc);
      int hc = 0;
      int qc = 0;
      int dq, dm;
      logic qv, mv;
      dq = $urandom_range(0, 8);
      dm = $urandom_range(0, 8);
      for (int j = 0; j < ncyc; j++) begin
         @(negedge clk);
         if (rst_n) observe();
         rst_n = 1'b1;
         case (kind)
            0: begin qv = 1'b1; mv = 1'b1; end
            1: begin qv = 1'b0; mv = ($urandom_range(0, 1) == 1); end
            2: begin qv = 1'b1; mv = 1'b0; end
            3: begin qv = 1'b0; mv = 1'b1; end
            4: begin qv = (j == 7); mv = (j == 7) || (j == 20); end
            5: begin qv = (j % 2 == 0); mv = (j % 4 < 2); end
            6: begin qv = 1'b1; mv = ($urandom_range(0, 2) == 0); end
            default: begin
               qv = ($urandom_range(0, 7) < dq);
               mv = ($urandom_range(0, 7) < dm);
            end
         endcase
         qual_b = qv;
         mon_b  = mv;
         qc += int'(qv);
         hc += int'(qv & mv);
         if (j == WIN - 1) begin
            exp_q   = ref_qual(qc);
            exp_m   = ref_mon(hc, qc);
            exp_tag = (kind == 0 || kind == 4) ? "R5" : (kind == 1) ? "R4" : "R3";
            due[0]  = pe + 1 + LAT_SER;
            due[1]  = pe + 1 + LAT_UNR;
         end
      end
   endtask

   task automatic drain();
      for (int c = 0; c < LAT_SER + 3; c++) begin
         @(negedge clk);
         observe();
         qual_b = 1'b0;
         mon_b  = 1'b0;
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      void'($urandom(32'h5EED_0417));
      due[0] = -1;
      due[1] = -1;
      reset_phase();
      for (int w = 0; w < 24; w++) run_window(w, WIN);
      run_window(9, 30);          // partial window, cut short by reset (R9)
      reset_phase();
      run_window(4, WIN);
      run_window(1, WIN);
      run_window(0, WIN);
      for (int w = 0; w < 3; w++) run_window(8 + w, WIN);
      drain();
      finished = 1;
      summary();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL R1 watchdog: got %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

endmodule